// File: doc/BRIEF.md
# Steerable Watchdog Timer

This block is a watchdog that software arms by writing one configuration byte. The byte combines a two-bit resolution code, a five-bit multiplier and a steering bit. The resolution code selects a power of four, and the multiplier scales it linearly. Their product is the timeout, counted in ticks of an external 16 Hz enable, so each tick is 1/16 s. A multiplier of zero leaves the watchdog disarmed.

Software keeps the watchdog from expiring in either of two ways. It can rewrite the configuration byte, which restarts the count from the new value. It can strobe a read of the status byte, which restarts the count from the byte already held. When the count runs out, the block sets a status flag. The steering bit then selects the consequence. With steering clear, the block pulses an interrupt for one cycle. With steering set, the block pulses a one-cycle request to the chip's reset controller, zeroes its configuration byte and clears a companion control bit. The block fires once per arming. It does not restart by itself.

Top module: `wdog_steer`

## Requirements
- R1: After synchronous reset, `cfg_o` is 0x00, `flags_o` is 0x00, `ctl_o` is 0, and `irq_o` and `reset_req_o` are low.
- R2: The configuration byte holds the resolution code in bits 1:0, the multiplier in bits 6:2 and steering in bit 7. A load sets a timeout of T = 4^res × mult ticks. Expiry takes effect at the clock edge that samples the T-th cycle with `tick_i` high after the load edge. Cycles with `tick_i` low do not count.
- R3: Expiry sets bit 7 of `flags_o`. Bits 6:0 of `flags_o` always read zero.
- R4: At expiry with steering clear, `irq_o` is high for exactly one cycle, `reset_req_o` stays low, and `cfg_o` keeps its value.
- R5: At expiry with steering set, `reset_req_o` is high for exactly one cycle, `irq_o` stays low, `cfg_o` becomes 0x00, and `ctl_o` becomes 0. All of these changes appear at the same edge.
- R6: A `cfg_wr_i` strobe stores `wr_data_i` in `cfg_o`, clears the flag and restarts the count from the new timeout.
- R7: A `flags_rd_i` strobe clears the flag and restarts the count from the timeout of the stored configuration.
- R8: A multiplier of zero never produces an expiry, whatever the ticks.
- R9: After an expiry, no further expiry occurs until the next load.
- R10: A load in the same cycle as a would-be expiry wins. No expiry occurs, and the count restarts.
- R11: A `ctl_wr_i` strobe stores bit 6 of `wr_data_i` in `ctl_o`.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | 16 Hz count enable, one cycle per tick |
| cfg_wr_i | input | 1 | Write strobe for the configuration byte |
| ctl_wr_i | input | 1 | Write strobe for the control bit |
| wr_data_i | input | 8 | Write data |
| flags_rd_i | input | 1 | Status read strobe; also restarts the count |
| cfg_o | output | 8 | Stored configuration byte |
| flags_o | output | 8 | Status byte; bit 7 is the expiry flag |
| ctl_o | output | 1 | Control bit, cleared by a steered expiry |
| irq_o | output | 1 | One-cycle interrupt pulse |
| reset_req_o | output | 1 | One-cycle reset request pulse |

## Verification
The count is hidden, so the bench can only see a wrong count as an expiry on the wrong edge. An off-by-one count shows up as a flag or pulse one cycle early or late. The bench sweeps every resolution and multiplier and checks the exact edge for each. If a restart was lost, expiry comes at the old deadline rather than the new one, and the bench checks this within a few cycles of each kick. A wrong steering decision shows on the same edge as the expiry: the wrong pulse fires, or the configuration byte or the control bit is not cleared.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int RES_W     = 2;
  localparam int MULT_W    = 5;
  localparam int RES_SHIFT = 2;
  localparam int CFG_W     = 1 + MULT_W + RES_W;
  localparam int CNT_W     = MULT_W + RES_SHIFT * ((1 << RES_W) - 1);

  typedef struct packed {
    logic              steer;
    logic [MULT_W-1:0] mult;
    logic [RES_W-1:0]  res;
  } wd_cfg_t;

  function automatic logic [CNT_W-1:0] timeout_units(wd_cfg_t c);
    logic [CNT_W-1:0] m;
    m = CNT_W'(c.mult);
    return m << (RES_SHIFT * int'(c.res));
  endfunction
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int CTL_BIT = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic             ctl_wr,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             kick_rd,
  input  logic             expire,
  output wd_cfg_t          cfg_q,
  output logic             flag_q,
  output logic             ctl_q,
  output logic             load,
  output logic [CNT_W-1:0] load_val
);
  wd_cfg_t next_cfg;

  assign load     = cfg_wr | kick_rd;
  assign next_cfg = cfg_wr ? wd_cfg_t'(wr_data) : cfg_q;
  assign load_val = timeout_units(next_cfg);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      flag_q <= 1'b0;
      ctl_q  <= 1'b0;
    end else begin
      if (cfg_wr)                    cfg_q <= wd_cfg_t'(wr_data);
      else if (expire && cfg_q.steer) cfg_q <= '0;

      if (load)        flag_q <= 1'b0;
      else if (expire) flag_q <= 1'b1;

      if (expire && cfg_q.steer) ctl_q <= 1'b0;
      else if (ctl_wr)           ctl_q <= wr_data[CTL_BIT];
    end
  end

  // R6/R7: a restart leaves the flag low on the following cycle
  assert_flag_cleared_R6: assert property (@(posedge clk) disable iff (rst)
    load |=> !flag_q);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expire
);
  logic [W-1:0] cnt_q;
  localparam logic [W-1:0] ONE = W'(1);

  assign expire = tick && !load && (cnt_q == ONE);

  always_ff @(posedge clk) begin
    if (rst)                      cnt_q <= '0;
    else if (load)                cnt_q <= load_val;
    else if (tick && cnt_q != '0) cnt_q <= cnt_q - ONE;
  end

  // R2: without a load the count never rises
  assert_no_rise_R2: assert property (@(posedge clk) disable iff (rst)
    !load |=> (cnt_q <= $past(cnt_q)));
  // R8/R9: an idle counter cannot expire
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0) |-> !expire);
endmodule

// File: rtl/wdog_action.sv
module wdog_action (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic steer,
  output logic irq_q,
  output logic rreq_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q  <= 1'b0;
      rreq_q <= 1'b0;
    end else begin
      irq_q  <= expire && !steer;
      rreq_q <= expire && steer;
    end
  end

  assert_irq_single_R4: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q);
  assert_rreq_single_R5: assert property (@(posedge clk) disable iff (rst)
    rreq_q |=> !rreq_q);
  assert_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    !(irq_q && rreq_q));
endmodule

// File: rtl/wdog_steer.sv
module wdog_steer
  import wdog_pkg::*;
#(
  parameter int FLAG_BIT = 7,
  parameter int CTL_BIT  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             cfg_wr_i,
  input  logic             ctl_wr_i,
  input  logic [CFG_W-1:0] wr_data_i,
  input  logic             flags_rd_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic [7:0]       flags_o,
  output logic             ctl_o,
  output logic             irq_o,
  output logic             reset_req_o
);
  wd_cfg_t          cfg_q;
  logic             flag_q;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             expire;

  wdog_regs #(.CTL_BIT(CTL_BIT)) u_regs (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr_i), .ctl_wr(ctl_wr_i),
    .wr_data(wr_data_i), .kick_rd(flags_rd_i), .expire(expire),
    .cfg_q(cfg_q), .flag_q(flag_q), .ctl_q(ctl_o),
    .load(load), .load_val(load_val)
  );

  wdog_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick_i), .load(load),
    .load_val(load_val), .expire(expire)
  );

  wdog_action u_act (
    .clk(clk), .rst(rst), .expire(expire), .steer(cfg_q.steer),
    .irq_q(irq_o), .rreq_q(reset_req_o)
  );

  assign cfg_o = cfg_q;

  always_comb begin
    flags_o           = '0;
    flags_o[FLAG_BIT] = flag_q;
  end

  // R5: a reset request arrives together with cleared configuration and control
  assert_steer_clears_R5: assert property (@(posedge clk) disable iff (rst)
    reset_req_o |-> (cfg_o == '0 && !ctl_o));
  // R3: every pulse is accompanied by the flag
  assert_pulse_has_flag_R3: assert property (@(posedge clk) disable iff (rst)
    (irq_o || reset_req_o) |-> flags_o[FLAG_BIT]);
  // R3: the flag only rises together with a pulse
  assert_flag_rise_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> (irq_o || reset_req_o));
endmodule

// File: tb/sim_wdog_steer.sv
module sim_wdog_steer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, cfg_wr = 1'b0, ctl_wr = 1'b0, frd = 1'b0;
  logic [7:0] wdat = '0;
  logic [7:0] cfg, flags;
  logic ctl, irq, rreq;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wdog_steer u0 (
    .clk(clk), .rst(rst), .tick_i(tick), .cfg_wr_i(cfg_wr), .ctl_wr_i(ctl_wr),
    .wr_data_i(wdat), .flags_rd_i(frd), .cfg_o(cfg), .flags_o(flags),
    .ctl_o(ctl), .irq_o(irq), .reset_req_o(rreq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [7:0] v);
    wdat = v; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic kick_rd();
    frd = 1'b1;
    @(negedge clk);
    frd = 1'b0;
  endtask

  function automatic int tmo(input logic [7:0] v);
    return int'(v[6:2]) << (2 * int'(v[1:0]));
  endfunction

  // load v, ticks every cycle, check exact expiry edge and action
  task automatic run_one(input logic [7:0] v);
    int t = tmo(v);
    int early = 0;
    wr_cfg(v);
    if (t == 0) begin
      for (int k = 0; k < 60; k++) begin
        @(negedge clk);
        if (flags[7] || irq || rreq) early++;
      end
      chk(early == 0, "R8 zero multiplier idle", early, 0);
      return;
    end
    for (int k = 1; k < t; k++) begin
      @(negedge clk);
      if (flags[7] || irq || rreq) early++;
    end
    chk(early == 0, "R2 no early expiry", early, 0);
    @(negedge clk);
    chk(flags == 8'h80, "R3 flag at expiry", flags, 8'h80);
    if (v[7]) begin
      chk(rreq && !irq && cfg == 8'h00, "R5 steered expiry",
          {rreq, irq, cfg}, {2'b10, 8'h00});
    end else begin
      chk(irq && !rreq && cfg == v, "R4 interrupt expiry",
          {rreq, irq, cfg}, {2'b01, v});
    end
    @(negedge clk);
    chk(!irq && !rreq, "R4 R5 single-cycle pulse", {rreq, irq}, 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(negedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    int cnt;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(cfg == 0 && flags == 0 && !ctl && !irq && !rreq, "R1 reset state",
        {cfg, flags, ctl, irq, rreq}, 0);

    // R11 control bit write
    wdat = 8'h40; ctl_wr = 1'b1; @(negedge clk); ctl_wr = 1'b0;
    chk(ctl == 1'b1, "R11 ctl set", ctl, 1);
    wdat = 8'hBF; ctl_wr = 1'b1; @(negedge clk); ctl_wr = 1'b0;
    chk(ctl == 1'b0, "R11 ctl uses bit 6 only", ctl, 0);

    tick = 1'b1;
    // R5 steered expiry also clears ctl
    wdat = 8'h40; ctl_wr = 1'b1; @(negedge clk); ctl_wr = 1'b0;
    run_one(8'h84);
    chk(ctl == 1'b0, "R5 ctl cleared", ctl, 0);

    // R2 R4 R5 R8: sweep every resolution and multiplier
    for (int r = 0; r < 4; r++)
      for (int m = 0; m < 32; m++)
        run_one({1'(m % 3 == 1), 5'(m), 2'(r)});

    // R9: no second expiry after one
    run_one(8'h0C);
    cnt = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (irq || rreq) cnt++;
    end
    chk(cnt == 0 && flags == 8'h80, "R9 one-shot", {cnt, flags}, 8'h80);

    // R7: read strobe clears the flag
    kick_rd();
    chk(flags == 8'h00, "R7 flag cleared by read", flags, 0);

    // R7: read restarts count from stored config (T=5)
    wr_cfg(8'h14);
    repeat (3) @(negedge clk);
    kick_rd();
    cnt = 0;
    for (int k = 1; k < 5; k++) begin
      @(negedge clk);
      if (flags[7] || irq) cnt++;
    end
    chk(cnt == 0, "R7 restart delays expiry", cnt, 0);
    @(negedge clk);
    chk(irq && flags == 8'h80, "R7 expiry after restart", {irq, flags}, {1'b1, 8'h80});

    // R6: rewrite with new value restarts from it (T=3 then T=8)
    wr_cfg(8'h0C);
    @(negedge clk);
    chk(flags == 8'h00, "R6 flag cleared by write", flags, 0);
    wr_cfg(8'h09);
    cnt = 0;
    for (int k = 1; k < 8; k++) begin
      @(negedge clk);
      if (flags[7] || irq) cnt++;
    end
    chk(cnt == 0 && cfg == 8'h09, "R6 new value governs", {cnt, cfg}, 8'h09);
    @(negedge clk);
    chk(irq, "R6 expiry at new timeout", irq, 1);

    // R10: load on the expiry edge wins (T=3)
    wr_cfg(8'h0C);
    repeat (2) @(negedge clk);
    wr_cfg(8'h0C);
    chk(!irq && flags == 0, "R10 load beats expiry", {irq, flags}, 0);
    repeat (2) @(negedge clk);
    chk(!irq, "R10 no early", irq, 0);
    @(negedge clk);
    chk(irq, "R10 expiry after reload", irq, 1);

    // R2: sparse ticks, T = 4*2 = 8 ticks, one tick every 3 cycles
    tick = 1'b0;
    wr_cfg(8'h09);
    cnt = 0;
    for (int k = 1; k <= 8; k++) begin
      repeat (2) begin
        @(negedge clk);
        if (flags[7] || irq) cnt++;
      end
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      if (k < 8 && (flags[7] || irq)) cnt++;
    end
    chk(cnt == 0 && irq && flags == 8'h80, "R2 sparse tick expiry",
        {cnt, irq, flags}, {1'b1, 8'h80});

    // R1: reset returns to idle
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk(cfg == 0 && flags == 0 && !irq && !rreq, "R1 reset again",
        {cfg, flags, irq, rreq}, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule